// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects level-sensitive interrupt lines in groups of 32, one group per bank, and turns them into a normal interrupt request and a fast interrupt request for a processor. Every bank has its own enable masks for the normal request, for the fast request and for an endpoint consumer. All three masks look at the same live view of the bank's input lines. Software reaches the banks through a plain 32-bit register port with word addresses. The bank number sits in the address bits just above a 16-byte window, and a register selector sits inside that window.

The block also reports which active source has the lowest number. A source counts when its line is high and its normal-request enable is set. This matches software that scans from bit 0 upward. Because the sources are levels, nothing is acknowledged: a line that falls simply drops out of the outputs. Vectoring, nesting and handler sequencing are left to software.

Top module: `banked_intc`

## Requirements
- R1: After reset every mask register of every bank reads 0, and `irq_o`, `fiq_o` and `pend_valid` are 0.
- R2: A read of a bank's cause word (window offset 0x0) returns that bank's live input lines, with bit k equal to `src_lvl[32*n+k]` for bank n. Writes to the cause word change nothing.
- R3: Window offset 0x4 holds the normal-request enable mask, 0x8 the fast-request enable mask and 0xC the endpoint mask. The bank is chosen by `bus_addr[5:4]`. A write takes effect at the clock edge that samples it and reads back unchanged. A bit set to 1 enables its source.
- R4: At each clock edge, `irq_o` is loaded with the OR over all banks of (cause AND normal mask) as sampled at that edge.
- R5: At each clock edge, `fiq_o` is loaded with the OR over all banks of (cause AND fast mask) as sampled at that edge.
- R6: The endpoint mask has no effect on `irq_o`, `fiq_o`, `pend_valid` or `pend_idx`.
- R7: At each clock edge, `pend_valid` is loaded with 1 when any source has its line high and its normal-request bit set. In that case `pend_idx` is loaded with the global number 32*bank+bit of the lowest such source.
- R8: An address with `bus_addr[1:0]` not zero, with any bit above bit 5 set, or with a bank number of `NUM_BANKS` or more reads 0, and a write to it changes no register.
- R9: No acknowledge is needed. When an enabled line goes low, the outputs it drove fall at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_BANKS*32 | Level interrupt lines, bank-major |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |
| pend_valid | output | 1 | `pend_idx` holds a valid source |
| pend_idx | output | $clog2(NUM_BANKS*32) | Lowest enabled pending global source number |

## Verification
Read data is combinational, so a register read is due in the same cycle as its address. The bench checks it shortly after it drives the address, between edges. A mask write lands at the edge that samples it, and the outputs that depend on it land one edge later. `irq_o`, `fiq_o`, `pend_valid` and `pend_idx` are due at the first edge after the lines and masks that produce them.

The bench's model computes these values at each rising edge from the inputs held since the previous falling edge. It then compares them with the design 2 ns after that edge. Directed cases cover the corner cases, and a random phase with mixed mapped and unmapped writes covers the rest.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int SRC_PER_BANK = 32;
   localparam int MAX_BANKS    = 4;
   localparam int WIN_LSB      = 4;   // bank field starts above the 16-byte window
   localparam int BANK_FLD_W   = 2;

   typedef enum logic [1:0] {
      SEL_CAUSE = 2'd0,
      SEL_IRQ   = 2'd1,
      SEL_FIQ   = 2'd2,
      SEL_EP    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int W = SRC_PER_BANK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  reg_sel_e     sel,
   input  logic [31:0]  wdata,
   input  logic [W-1:0] src,
   output logic [W-1:0] irq_mask,
   output logic [W-1:0] fiq_mask,
   output logic [W-1:0] ep_mask,
   output logic [31:0]  rd_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_mask <= '0;
         fiq_mask <= '0;
         ep_mask  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_IRQ: irq_mask <= wdata[W-1:0];
            SEL_FIQ: fiq_mask <= wdata[W-1:0];
            SEL_EP:  ep_mask  <= wdata[W-1:0];
            default: ;   // cause view is read-only
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_CAUSE: rd_data = src;
         SEL_IRQ:   rd_data = irq_mask;
         SEL_FIQ:   rd_data = fiq_mask;
         default:   rd_data = ep_mask;
      endcase
   end
endmodule

// File: rtl/intc_lowest_enc.sv
module intc_lowest_enc #(
   parameter int N     = 32,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [IW-1:0] idx
);
   // Scan from the top down so the lowest set bit is assigned last and wins.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/banked_intc.sv
module banked_intc
   import intc_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 8,
   localparam int SRC_N    = NUM_BANKS * SRC_PER_BANK,
   localparam int IDX_W    = $clog2(SRC_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] src_lvl,
   input  logic             bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             irq_o,
   output logic             fiq_o,
   output logic             pend_valid,
   output logic [IDX_W-1:0] pend_idx
);
   localparam int TOP_LSB = WIN_LSB + BANK_FLD_W;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("banked_intc: NUM_BANKS must be 1..4");
      end
      if (ADDR_W <= TOP_LSB) begin : g_bad_addr
         $error("banked_intc: ADDR_W must exceed the bank field");
      end
   endgenerate

   logic [BANK_FLD_W-1:0] bank_f;
   reg_sel_e              sel;
   logic                  hit;

   assign bank_f = bus_addr[TOP_LSB-1:WIN_LSB];
   assign sel    = reg_sel_e'(bus_addr[WIN_LSB-1:2]);
   assign hit    = (bus_addr[1:0] == 2'b00)
                && (bus_addr[ADDR_W-1:TOP_LSB] == '0)
                && (int'(bank_f) < NUM_BANKS);

   logic [SRC_N-1:0] irq_mask_all, fiq_mask_all, ep_mask_all;
   logic [31:0]      bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_b;
      assign wr_b = bus_wr_en && hit && (int'(bank_f) == b);
      intc_bank #(.W(SRC_PER_BANK)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_b),
         .sel     (sel),
         .wdata   (bus_wdata),
         .src     (src_lvl[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .irq_mask(irq_mask_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .fiq_mask(fiq_mask_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .ep_mask (ep_mask_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .rd_data (bank_rd[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit && int'(bank_f) == b) bus_rdata = bank_rd[b];
      end
   end

   logic [SRC_N-1:0] act_irq, act_fiq;
   logic             enc_found;
   logic [IDX_W-1:0] enc_idx;

   assign act_irq = src_lvl & irq_mask_all;
   assign act_fiq = src_lvl & fiq_mask_all;

   intc_lowest_enc #(.N(SRC_N)) u_enc (
      .vec  (act_irq),
      .found(enc_found),
      .idx  (enc_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o      <= 1'b0;
         fiq_o      <= 1'b0;
         pend_valid <= 1'b0;
         pend_idx   <= '0;
      end else begin
         irq_o      <= |act_irq;
         fiq_o      <= |act_fiq;
         pend_valid <= enc_found;
         pend_idx   <= enc_idx;
      end
   end
endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk
   import intc_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 8,
   localparam int SRC_N    = NUM_BANKS * SRC_PER_BANK,
   localparam int IDX_W    = $clog2(SRC_N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SRC_N-1:0] src_lvl,
   input logic             bus_wr_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic             irq_o,
   input logic             fiq_o,
   input logic             pend_valid,
   input logic [IDX_W-1:0] pend_idx,
   input logic [SRC_N-1:0] irq_mask_all,
   input logic [SRC_N-1:0] fiq_mask_all
);
   logic [SRC_N-1:0] prev_act;
   always_ff @(posedge clk) begin
      if (!rst_n) prev_act <= '0;
      else        prev_act <= src_lvl & irq_mask_all;
   end

   // R1
   mask_reset_chk: assert property (@(posedge clk)
      !rst_n |=> (irq_mask_all == '0 && fiq_mask_all == '0 && !irq_o && !fiq_o));

   // R4
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o == $past(|(src_lvl & irq_mask_all)));

   // R5
   fiq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> fiq_o == $past(|(src_lvl & fiq_mask_all)));

   // R7
   pend_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid == irq_o);

   // R7
   pend_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (prev_act[pend_idx]
                      && ((prev_act & ((SRC_N'(1) << pend_idx) - SRC_N'(1))) == '0)));

   // R2
   cause_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr[3:0] == 4'h0) |=> ($stable(irq_mask_all) && $stable(fiq_mask_all)));
endmodule

bind banked_intc banked_intc_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_lvl     (src_lvl),
   .bus_wr_en   (bus_wr_en),
   .bus_addr    (bus_addr),
   .irq_o       (irq_o),
   .fiq_o       (fiq_o),
   .pend_valid  (pend_valid),
   .pend_idx    (pend_idx),
   .irq_mask_all(irq_mask_all),
   .fiq_mask_all(fiq_mask_all)
);

// File: tb/banked_intc_test.sv
`timescale 1ns/1ps
module banked_intc_test;
   localparam int NB = 3;
   localparam int SN = NB * 32;
   localparam int IW = $clog2(SN);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SN-1:0] src_lvl = '0;
   logic          bus_wr_en = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o, fiq_o, pend_valid;
   logic [IW-1:0] pend_idx;

   banked_intc #(.NUM_BANKS(NB), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr_en(bus_wr_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o), .pend_valid(pend_valid), .pend_idx(pend_idx)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int failures = 0;

   // reference model state
   logic [31:0] m_irq [NB];
   logic [31:0] m_fiq [NB];
   logic [31:0] m_ep  [NB];
   logic        e_irq = 1'b0, e_fiq = 1'b0, e_pv = 1'b0;
   int          e_pi = 0;

   function automatic bit decode(input logic [7:0] a, output int bk, output int rs);
      bk = int'(a[5:4]);
      rs = int'(a[3:2]);
      return (a[1:0] == 2'b00) && (a[7:6] == 2'b00) && (bk < NB);
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      int bk, rs;
      if (!decode(a, bk, rs)) return 32'h0;
      case (rs)
         0: return src_lvl[bk*32 +: 32];
         1: return m_irq[bk];
         2: return m_fiq[bk];
         default: return m_ep[bk];
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            m_irq[b] = '0; m_fiq[b] = '0; m_ep[b] = '0;
         end
         e_irq = 0; e_fiq = 0; e_pv = 0; e_pi = 0;
      end else begin
         int bk, rs;
         e_irq = 0; e_fiq = 0; e_pv = 0; e_pi = 0;
         for (int i = 0; i < SN; i++) begin
            if (src_lvl[i] && m_irq[i/32][i%32]) begin
               e_irq = 1;
               if (!e_pv) begin e_pv = 1; e_pi = i; end
            end
            if (src_lvl[i] && m_fiq[i/32][i%32]) e_fiq = 1;
         end
         if (bus_wr_en && decode(bus_addr, bk, rs)) begin
            case (rs)
               1: m_irq[bk] = bus_wdata;
               2: m_fiq[bk] = bus_wdata;
               3: m_ep[bk]  = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, 2 ns after each edge
   always @(posedge clk) begin
      #2;
      chk("R4 irq_o", 32'(irq_o), 32'(e_irq));
      chk("R5 fiq_o", 32'(fiq_o), 32'(e_fiq));
      chk("R7 pend_valid", 32'(pend_valid), 32'(e_pv));
      if (e_pv) chk("R7 pend_idx", 32'(pend_idx), 32'(e_pi));
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, model_read(a));
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, e);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state
      chk("R1 irq_o", 32'(irq_o), 0);
      chk("R1 pend_valid", 32'(pend_valid), 0);
      for (int b = 0; b < NB; b++) begin
         rd_exp(8'(b*16 + 4), 0, "R1 irq mask");
         rd_exp(8'(b*16 + 8), 0, "R1 fiq mask");
         rd_exp(8'(b*16 + 12), 0, "R1 ep mask");
      end

      // R2 cause follows lines; writes to it ignored
      @(negedge clk);
      src_lvl = {32'h0000_0001, 32'h8000_0020, 32'h0000_0008};
      rd_exp(8'h10, 32'h8000_0020, "R2 cause bank1");
      wr(8'h10, 32'hFFFF_FFFF);
      rd_exp(8'h10, 32'h8000_0020, "R2 cause after write");
      rd_exp(8'h14, 0, "R2 irq mask untouched");
      settle(1);
      chk("R2 irq_o idle", 32'(irq_o), 0);

      // R3 / R4 / R7 bank1 bit 5 -> global 37
      wr(8'h14, 32'h0000_0020);
      rd_exp(8'h14, 32'h0000_0020, "R3 irq mask readback");
      settle(1);
      chk("R4 irq from bank1", 32'(irq_o), 1);
      chk("R7 idx 37", 32'(pend_idx), 37);

      // R7 lower source in bank0 wins
      wr(8'h04, 32'h0000_0008);
      settle(1);
      chk("R7 idx 3 lowest", 32'(pend_idx), 3);

      // R5 fast request from bank2 bit0
      wr(8'h28, 32'h0000_0001);
      rd_exp(8'h28, 32'h0000_0001, "R3 fiq mask readback");
      settle(1);
      chk("R5 fiq from bank2", 32'(fiq_o), 1);

      // R9 level drop without acknowledge
      @(negedge clk);
      src_lvl = '0;
      settle(1);
      chk("R9 irq falls", 32'(irq_o), 0);
      chk("R9 fiq falls", 32'(fiq_o), 0);

      // R6 endpoint mask has no effect
      wr(8'h04, 0); wr(8'h14, 0); wr(8'h28, 0);
      for (int b = 0; b < NB; b++) wr(8'(b*16 + 12), 32'hFFFF_FFFF);
      rd_exp(8'h2C, 32'hFFFF_FFFF, "R3 ep mask readback");
      @(negedge clk);
      src_lvl = '1;
      settle(2);
      chk("R6 irq_o", 32'(irq_o), 0);
      chk("R6 fiq_o", 32'(fiq_o), 0);
      chk("R6 pend_valid", 32'(pend_valid), 0);

      // R8 unmapped addresses
      wr(8'h34, 32'hFFFF_FFFF);   // bank 3 absent
      wr(8'h05, 32'hFFFF_FFFF);   // misaligned
      wr(8'h44, 32'hFFFF_FFFF);   // upper bit set
      rd_exp(8'h34, 0, "R8 absent bank read");
      rd_exp(8'h45, 0, "R8 misaligned read");
      rd_exp(8'h40, 0, "R8 upper bit read");
      rd_exp(8'h04, 0, "R8 bank0 irq mask untouched");
      settle(1);
      chk("R8 irq_o stays low", 32'(irq_o), 0);

      // random phase, model compared every cycle
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         src_lvl = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
         bus_wr_en = ($urandom % 3 == 0);
         bus_addr  = 8'($urandom % 80);
         bus_wdata = $urandom & $urandom;
         if (c % 8 == 0) begin
            #1;
            chk("R3 random read", bus_rdata, model_read(bus_addr));
         end
      end
      @(negedge clk);
      bus_wr_en = 1'b0;
      for (int a = 0; a < 64; a += 4) rd(8'(a), "R8 final read sweep");
      settle(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule